// File: doc/BRIEF.md
# Launch-on-Capture Scan Self-Test Sequencer

This block steers a scan-based logic self-test that uses launch-on-capture timing. After a start request it latches a pattern total and a chain length. It then runs a shift phase: scan enable stays high and one shift strobe is issued per cycle until the longest chain has been refilled. Next comes a capture phase with scan enable low. It issues a launch (update) strobe, which applies the freshly loaded vector to the logic under test. One idle cycle follows, and then a capture strobe, which samples the response back into the chains. Scan cells keep showing the previously applied vector for the whole shift phase, so the only strobe that changes what the logic under test sees is the launch strobe.

Each response is unloaded during the shift phase that loads the next vector. A signature-enable strobe accompanies the shift cycles that carry a response. After the final capture, one extra shift phase flushes the last response. Then a one-cycle done pulse ends the run. The chains, pattern source and signature register sit outside the block and are driven by its strobes.

The controller moves through six named states. IDLE waits for start. SHIFT runs one strobe per cycle for the latched length. LAUNCH issues the update strobe. GAP is the silent cycle between the two capture-phase strobes. CAPT issues the capture strobe. DONE emits the completion pulse. The transitions are as follows:
- IDLE→SHIFT on an accepted start with a non-zero total.
- IDLE→DONE on an accepted start with a zero total.
- SHIFT→SHIFT while bits remain in the phase.
- SHIFT→LAUNCH at the last bit while patterns remain.
- SHIFT→DONE at the last bit once every pattern has been captured.
- LAUNCH→GAP, GAP→CAPT and CAPT→SHIFT, each unconditional.
- DONE→IDLE with no start, or DONE→SHIFT/DONE when a start arrives in the done cycle.

Top module: `lbist_loc_sequencer`

## Requirements
- R1: While reset is asserted and after its release with no start, scan_en_o, shift_o, update_o, capture_o, sig_en_o, busy_o and done_o are all low.
- R2: Every shift phase holds scan_en_o and shift_o high together for exactly L consecutive cycles. L is the latched chain length, and a programmed length of 0 counts as 1. shift_o is never high while scan_en_o is low.
- R3: After each shift phase that loads a vector, scan_en_o is low and update_o is high for one cycle. One cycle follows with no strobe. capture_o is then high for one cycle, exactly two cycles after update_o, and the next shift phase starts in the following cycle.
- R4: update_o is never high while scan_en_o is high, so the vector seen by the logic under test changes only at the launch strobe.
- R5: sig_en_o is high exactly on the shift cycles of every shift phase except the first, which gives P×L cycles for a run of P patterns.
- R6: A run of P>0 patterns issues P update strobes, P capture strobes and (P+1)×L shift strobes. done_o rises P×(L+3)+L+1 cycles after the cycle in which start was applied, lasts one cycle, and coincides with busy_o low.
- R7: An accepted start with a pattern total of 0 gives done_o in the next cycle, with no shift, update, capture or signature strobe.
- R8: busy_o is high from the cycle after an accepted start until done_o. A start while busy_o is high is ignored, and the running sequence is unchanged.
- R9: The pattern total and chain length are latched when start is accepted. Later changes to those inputs do not alter the run. A start is also accepted in the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to begin a run; taken only while busy_o is low |
| pat_total_i | input | PAT_W | Number of patterns to apply |
| chain_len_i | input | LEN_W | Length of the longest scan chain (0 treated as 1) |
| scan_en_o | output | 1 | Scan enable, high during shift phases |
| shift_o | output | 1 | Shift clock enable, one per shifted bit |
| update_o | output | 1 | Launch strobe applying the loaded vector |
| capture_o | output | 1 | Capture strobe sampling the response |
| sig_en_o | output | 1 | Signature register enable during response unload |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach from the ports is a start that arrives while the block is busy, especially when it carries a different total and length that could corrupt the latched values. The stimulus pulses start in the middle of randomly chosen runs and leaves the pattern and length inputs altered until done. It then compares strobe counts and done latency with the originally programmed values. Starts issued in the very cycle done is high, and zero-pattern and zero-length settings, are added as directed corner cases.

// File: rtl/lbist_seq_pkg.sv
package lbist_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_LAUNCH,
        ST_GAP,
        ST_CAPT,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/lbist_bit_counter.sv
module lbist_bit_counter #(
    parameter int LEN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             step_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             last_o
);

    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] len_m1;

    // a length of zero behaves as a single-bit chain
    assign len_m1 = (len_i == '0) ? '0 : len_i - 1'b1;
    assign last_o = (cnt_q == len_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (step_i) begin
            cnt_q <= last_o ? '0 : cnt_q + 1'b1;
        end
    end

    // R2: bit index never passes the end of the phase
    assert_bit_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |-> cnt_q <= len_m1)
        else $error("bit counter beyond chain length");

    // R2: the last bit of a phase wraps the counter
    assert_bit_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && last_o) |=> cnt_q == '0)
        else $error("bit counter did not wrap");

endmodule

// File: rtl/lbist_pat_counter.sv
module lbist_pat_counter #(
    parameter int PAT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             inc_i,
    input  logic [PAT_W-1:0] total_i,
    output logic             all_o,
    output logic             pend_o
);

    logic [PAT_W-1:0] cnt_q;

    assign all_o  = (cnt_q == total_i);
    assign pend_o = (cnt_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6: captures never exceed the programmed total
    assert_pat_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |-> cnt_q <= total_i)
        else $error("pattern count beyond total");

endmodule

// File: rtl/lbist_loc_fsm.sv
module lbist_loc_fsm
    import lbist_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic zero_pat_i,
    input  logic bit_last_i,
    input  logic pats_all_i,
    input  logic resp_pend_i,
    output logic accept_o,
    output logic bit_step_o,
    output logic pat_inc_o,
    output logic scan_en_o,
    output logic shift_o,
    output logic update_o,
    output logic capture_o,
    output logic sig_en_o,
    output logic busy_o,
    output logic done_o
);

    seq_state_e state_q, state_d;
    logic       idle_like;

    assign idle_like = (state_q == ST_IDLE) || (state_q == ST_DONE);
    assign accept_o  = start_i && idle_like;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    state_d = zero_pat_i ? ST_DONE : ST_SHIFT;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_SHIFT: begin
                if (bit_last_i) begin
                    state_d = pats_all_i ? ST_DONE : ST_LAUNCH;
                end
            end
            ST_LAUNCH: state_d = ST_GAP;
            ST_GAP:    state_d = ST_CAPT;
            ST_CAPT:   state_d = ST_SHIFT;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        scan_en_o  = 1'b0;
        shift_o    = 1'b0;
        update_o   = 1'b0;
        capture_o  = 1'b0;
        sig_en_o   = 1'b0;
        busy_o     = 1'b1;
        done_o     = 1'b0;
        bit_step_o = 1'b0;
        pat_inc_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: busy_o = 1'b0;
            ST_SHIFT: begin
                scan_en_o  = 1'b1;
                shift_o    = 1'b1;
                sig_en_o   = resp_pend_i;
                bit_step_o = 1'b1;
            end
            ST_LAUNCH: update_o = 1'b1;
            ST_GAP:    ;
            ST_CAPT: begin
                capture_o = 1'b1;
                pat_inc_o = 1'b1;
            end
            ST_DONE: begin
                busy_o = 1'b0;
                done_o = 1'b1;
            end
            default: busy_o = 1'b0;
        endcase
    end

    // R3: a capture strobe comes exactly two cycles after a launch strobe
    assert_capture_after_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        capture_o |-> $past(update_o, 2))
        else $error("capture without launch two cycles earlier");

    // R4: after a launch the chains are not shifting and no second launch follows
    assert_launch_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        update_o |=> (!scan_en_o && !update_o && !capture_o))
        else $error("strobe right after launch");

    // R6: done is a single-cycle pulse unless a new zero-pattern run starts
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> !done_o)
        else $error("done held longer than a cycle");

    // R8: busy and done are never high together
    assert_busy_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o))
        else $error("busy and done overlap");

endmodule

// File: rtl/lbist_loc_sequencer.sv
module lbist_loc_sequencer #(
    parameter int PAT_W = 16,
    parameter int LEN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [PAT_W-1:0] pat_total_i,
    input  logic [LEN_W-1:0] chain_len_i,
    output logic             scan_en_o,
    output logic             shift_o,
    output logic             update_o,
    output logic             capture_o,
    output logic             sig_en_o,
    output logic             busy_o,
    output logic             done_o
);

    logic [PAT_W-1:0] total_q;
    logic [LEN_W-1:0] len_q;
    logic             accept;
    logic             bit_step;
    logic             bit_last;
    logic             pat_inc;
    logic             pats_all;
    logic             resp_pend;
    logic             zero_pat;

    assign zero_pat = (pat_total_i == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            total_q <= '0;
            len_q   <= '0;
        end else if (accept) begin
            total_q <= pat_total_i;
            len_q   <= chain_len_i;
        end
    end

    lbist_loc_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .zero_pat_i  (zero_pat),
        .bit_last_i  (bit_last),
        .pats_all_i  (pats_all),
        .resp_pend_i (resp_pend),
        .accept_o    (accept),
        .bit_step_o  (bit_step),
        .pat_inc_o   (pat_inc),
        .scan_en_o   (scan_en_o),
        .shift_o     (shift_o),
        .update_o    (update_o),
        .capture_o   (capture_o),
        .sig_en_o    (sig_en_o),
        .busy_o      (busy_o),
        .done_o      (done_o)
    );

    lbist_bit_counter #(.LEN_W(LEN_W)) u_bits (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (accept),
        .step_i  (bit_step),
        .len_i   (len_q),
        .last_o  (bit_last)
    );

    lbist_pat_counter #(.PAT_W(PAT_W)) u_pats (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (accept),
        .inc_i   (pat_inc),
        .total_i (total_q),
        .all_o   (pats_all),
        .pend_o  (resp_pend)
    );

    // R8 R9: a start while busy leaves the latched settings untouched
    assert_hold_settings_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> ($stable(total_q) && $stable(len_q)))
        else $error("settings changed during a run");

endmodule

// File: tb/test_lbist_loc_sequencer.sv
module test_lbist_loc_sequencer;

    localparam int PAT_W = 16;
    localparam int LEN_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [PAT_W-1:0] pat_total_i = '0;
    logic [LEN_W-1:0] chain_len_i = '0;
    logic scan_en_o, shift_o, update_o, capture_o, sig_en_o, busy_o, done_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    lbist_loc_sequencer #(.PAT_W(PAT_W), .LEN_W(LEN_W)) i_lbist_loc_sequencer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .pat_total_i (pat_total_i),
        .chain_len_i (chain_len_i),
        .scan_en_o   (scan_en_o),
        .shift_o     (shift_o),
        .update_o    (update_o),
        .capture_o   (capture_o),
        .sig_en_o    (sig_en_o),
        .busy_o      (busy_o),
        .done_o      (done_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff_len(input int l);
        return (l == 0) ? 1 : l;
    endfunction

    function automatic int exp_done_cycle(input int p, input int l);
        if (p == 0) return 1;
        return p * (eff_len(l) + 3) + eff_len(l) + 1;
    endfunction

    // start is applied at a negedge; sample j is the j-th negedge after the accepting edge
    task automatic run_case(input int p, input int l, input bit poke);
        int j = 1;
        int run = 0, shifts = 0, sigs = 0, upds = 0, capts = 0;
        int bad_phase = 0, bad_launch = 0, bad_cap = 0, bad_shift = 0, bad_busy = 0;
        int last_upd = -10;
        int done_at = -1;
        int le = eff_len(l);
        pat_total_i = PAT_W'(p);
        chain_len_i = LEN_W'(l);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (j < 6000) begin
            if (scan_en_o) begin
                run++;
                if (shift_o) shifts++;
                if (sig_en_o) sigs++;
            end else begin
                if (run != 0 && run != le) bad_phase++;
                run = 0;
                if (shift_o) bad_shift++;
                if (sig_en_o) bad_shift++;
            end
            if (update_o) begin
                upds++;
                last_upd = j;
                if (scan_en_o) bad_launch++;
            end
            if (capture_o) begin
                capts++;
                if (last_upd != j - 2) bad_cap++;
            end
            if (done_o) begin
                done_at = j;
                chk(!busy_o, "R6 busy low at done", int'(busy_o), 0);
                break;
            end else if (!busy_o) begin
                bad_busy++;
            end
            if (poke && j == 3) begin
                start_i = 1'b1;
                pat_total_i = PAT_W'(p + 7);
                chain_len_i = LEN_W'(l + 5);
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            j++;
        end
        start_i = 1'b0;
        if (p == 0) begin
            chk(done_at == 1, "R7 zero-pattern done latency", done_at, 1);
            chk(shifts + upds + capts + sigs == 0, "R7 zero-pattern strobes", shifts + upds + capts + sigs, 0);
        end else begin
            chk(done_at == exp_done_cycle(p, l), "R6 done latency", done_at, exp_done_cycle(p, l));
            chk(shifts == (p + 1) * le, "R2 shift strobe count", shifts, (p + 1) * le);
            chk(upds == p, "R3 update count", upds, p);
            chk(capts == p, "R3 capture count", capts, p);
            chk(sigs == p * le, "R5 signature enable count", sigs, p * le);
        end
        chk(bad_phase == 0, "R2 shift phase length", bad_phase, 0);
        chk(bad_shift == 0, "R2 shift or sig without scan enable", bad_shift, 0);
        chk(bad_launch == 0, "R4 update during scan enable", bad_launch, 0);
        chk(bad_cap == 0, "R3 capture two cycles after update", bad_cap, 0);
        chk(bad_busy == 0, "R8 busy held through run", bad_busy, 0);
        if (poke) chk(done_at == exp_done_cycle(p, l), "R9 settings latched, start ignored", done_at, exp_done_cycle(p, l));
    endtask

    initial begin
        #(20 * 190000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk({scan_en_o, shift_o, update_o, capture_o, sig_en_o, busy_o, done_o} == 7'b0,
            "R1 outputs low in reset", int'({scan_en_o, shift_o, update_o, capture_o, sig_en_o, busy_o, done_o}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk({scan_en_o, shift_o, update_o, capture_o, sig_en_o, busy_o, done_o} == 7'b0,
            "R1 outputs low idle", int'({scan_en_o, shift_o, update_o, capture_o, sig_en_o, busy_o, done_o}), 0);

        // directed corners
        run_case(0, 4, 1'b0);   // R7
        run_case(1, 1, 1'b0);
        run_case(1, 0, 1'b0);   // R2 zero length counts as one
        run_case(3, 5, 1'b1);   // R8 R9 start while busy
        run_case(2, 3, 1'b0);   // started in the done cycle of the previous run (R9)
        run_case(0, 0, 1'b0);   // zero total started in a done cycle
        @(negedge clk);
        @(negedge clk);
        chk(!busy_o && !done_o, "R1 idle after done", int'({busy_o, done_o}), 0);

        for (int k = 0; k < 24; k++) begin
            int p = $urandom_range(0, 5);
            int l = $urandom_range(0, 12);
            bit poke = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 1) == 1) @(negedge clk);
            run_case(p, l, poke && p > 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule